// File: doc/BRIEF.md
# Read-after-write stall controller for a forwarding-free five-stage pipeline

This block decides when an in-order, five-stage pipeline without result forwarding must freeze its front end. The instruction sitting in decode names up to two source registers. Each of the three later stages (execute, memory, write-back) carries the destination index and write enable of the instruction it holds. If a source matches a pending write, the program counter and the decode register freeze. A no-write bubble then goes into execute, and this repeats until the producing instruction has left the pipeline.

To keep the block self-contained and testable, the top module includes a skeleton of the pipeline around the detector. A program counter steps through instructions supplied by the surrounding logic. The decode register is followed by a chain of three write tags. The last tag drives the single write port of a register file that has two read ports. A parameter selects whether the write-back stage still counts as a conflict. When the register file writes in the first half of the cycle, that stage does not need to count.

Top module: `raw_stall_pipe`

## Requirements
- R1: After a synchronous reset, `pc` is 0, `stall` is 0, `bubble` is 1 (decode is empty) and `wb_we` is 0.
- R2: The rs index in decode is compared against the destination index in the execute, memory and write-back stages. While any of these matches, `stall` is 1. With write-back counting, a consumer directly after its producer stalls for exactly 3 cycles.
- R3: The rt index is compared only when the decode instruction marks rt as read (`in_rt_used` = 1). An rt match with `in_rt_used` = 0 causes no stall.
- R4: A stage's destination index takes part in a comparison only when that stage's write enable is 1.
- R5: Source index 0 never causes a stall, even if a stage writes index 0 with its enable set.
- R6: While `stall` is 1, `pc` and the decode register keep their values. Otherwise `pc` advances by 4 on each clock, so after N clocks from reset `pc` equals 4 × (N − stalled cycles).
- R7: `bubble` is 1 whenever `stall` is 1 or decode is empty. A bubble enters execute with its write enable cleared. As a result, `wb_we` pulses exactly once per writing instruction, in program order, with `wb_idx` equal to that instruction's destination.
- R8: When the write-back stage does not count as a conflict (`MEMWB_HAZ` = 0), a consumer directly after its producer stalls for exactly 2 cycles.
- R9: If k independent instructions separate the producer from the consumer, the consumer stalls for max(0, 3 − k) cycles with write-back counting, and max(0, 2 − k) cycles without it.
- R10: When rs and rt conflict with writes in different stages in the same cycle, the stall lasts until the younger producer clears. The older producer clearing does not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_rs | input | 5 | First source index of the instruction at `pc` |
| in_rt | input | 5 | Second source index of the instruction at `pc` |
| in_rt_used | input | 1 | 1 when that instruction reads its second source |
| in_wr_idx | input | 5 | Destination index of the instruction at `pc` |
| in_wr_en | input | 1 | 1 when that instruction writes a register |
| pc | output | PC_W | Fetch address, held while stalled |
| stall | output | 1 | Freeze program counter and decode register |
| bubble | output | 1 | Control entering execute is cleared this cycle |
| wb_we | output | 1 | Register-file write enable from the write-back stage |
| wb_idx | output | 5 | Register-file write index from the write-back stage |

## Verification
The case that needs the most care is when both source comparisons fire in the same cycle against two different stages. The rt source matches an older producer in the memory stage, and the rs source matches a younger one in execute. To provoke it, two back-to-back writers are placed directly ahead of an instruction that reads both of their destinations. The run is judged by the total number of stall cycles, which must equal the younger producer's stall count (3, or 2 without write-back counting). It is also judged by the register-file write sequence, which must still show each destination exactly once and in program order.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int IDX_W  = 5;
  localparam int NSTAGE = 3;   // execute, memory, write-back

  typedef logic [IDX_W-1:0] ridx_t;

  typedef struct packed {
    logic  we;
    ridx_t idx;
  } wtag_t;

  typedef struct packed {
    logic  vld;
    ridx_t rs;
    ridx_t rt;
    logic  rt_used;
    wtag_t wr;
  } dec_t;
endpackage

// File: rtl/hz_match.sv
module hz_match
  import hz_pkg::*;
(
  input  ridx_t src,
  input  logic  src_used,
  input  wtag_t tag,
  output logic  hit
);
  // Index zero is hard-wired in the register file and never pending.
  always_comb begin
    hit = src_used && (src != '0) && tag.we && (tag.idx == src);
  end
endmodule

// File: rtl/hz_detect.sv
module hz_detect
  import hz_pkg::*;
#(
  parameter bit MEMWB_HAZ = 1'b1
) (
  input  dec_t  dec,
  input  wtag_t tags [NSTAGE],
  output logic  hazard
);
  localparam int NCMP = MEMWB_HAZ ? NSTAGE : NSTAGE - 1;

  logic [2*NSTAGE-1:0] hits;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_st
    if (s < NCMP) begin : g_on
      hz_match m_rs (
        .src      (dec.rs),
        .src_used (1'b1),
        .tag      (tags[s]),
        .hit      (hits[2*s])
      );
      hz_match m_rt (
        .src      (dec.rt),
        .src_used (dec.rt_used),
        .tag      (tags[s]),
        .hit      (hits[2*s+1])
      );
    end else begin : g_off
      assign hits[2*s]   = 1'b0;
      assign hits[2*s+1] = 1'b0;
    end
  end

  always_comb begin
    hazard = dec.vld && (|hits);
  end
endmodule

// File: rtl/hz_stage_reg.sv
module hz_stage_reg #(
  parameter type T = logic
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  input  T     d,
  output T     q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= d;
  end
endmodule

// File: rtl/raw_stall_pipe.sv
module raw_stall_pipe
  import hz_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int PC_STEP   = 4,
  parameter bit MEMWB_HAZ = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] in_rs,
  input  logic [IDX_W-1:0] in_rt,
  input  logic             in_rt_used,
  input  logic [IDX_W-1:0] in_wr_idx,
  input  logic             in_wr_en,
  output logic [PC_W-1:0]  pc,
  output logic             stall,
  output logic             bubble,
  output logic             wb_we,
  output logic [IDX_W-1:0] wb_idx
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  dec_t  fetched, ifid_q;
  wtag_t idex_q, exmem_q, memwb_q;
  wtag_t tags [NSTAGE];
  logic  hazard;

  always_comb begin
    fetched.vld     = 1'b1;
    fetched.rs      = in_rs;
    fetched.rt      = in_rt;
    fetched.rt_used = in_rt_used;
    fetched.wr.we   = in_wr_en;
    fetched.wr.idx  = in_wr_idx;
  end

  always_ff @(posedge clk) begin
    if (rst)         pc <= '0;
    else if (!stall) pc <= pc + STEP;
  end

  hz_stage_reg #(.T(dec_t)) u_ifid (
    .clk (clk), .rst (rst), .en (!stall), .clr (1'b0),
    .d   (fetched), .q (ifid_q)
  );

  hz_stage_reg #(.T(wtag_t)) u_idex (
    .clk (clk), .rst (rst), .en (1'b1), .clr (bubble),
    .d   (ifid_q.wr), .q (idex_q)
  );

  hz_stage_reg #(.T(wtag_t)) u_exmem (
    .clk (clk), .rst (rst), .en (1'b1), .clr (1'b0),
    .d   (idex_q), .q (exmem_q)
  );

  hz_stage_reg #(.T(wtag_t)) u_memwb (
    .clk (clk), .rst (rst), .en (1'b1), .clr (1'b0),
    .d   (exmem_q), .q (memwb_q)
  );

  always_comb begin
    tags[0] = idex_q;
    tags[1] = exmem_q;
    tags[2] = memwb_q;
  end

  hz_detect #(.MEMWB_HAZ(MEMWB_HAZ)) u_det (
    .dec    (ifid_q),
    .tags   (tags),
    .hazard (hazard)
  );

  always_comb begin
    stall  = hazard;
    bubble = hazard || !ifid_q.vld;
    wb_we  = memwb_q.we;
    wb_idx = memwb_q.idx;
  end

  // R6: front end frozen while stalled
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> (pc == $past(pc)));
  a_r6_ifid_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> (ifid_q == $past(ifid_q)));

  // R7: a bubble carries no write into execute
  a_r7_bubble_no_write: assert property (@(posedge clk) disable iff (rst)
    bubble |=> !idex_q.we);

  // R5: sources at index zero never stall
  a_r5_zero_src: assert property (@(posedge clk) disable iff (rst)
    (ifid_q.rs == '0 && (!ifid_q.rt_used || ifid_q.rt == '0)) |-> !stall);

  // R4: nothing pending means nothing to wait for
  a_r4_no_pending: assert property (@(posedge clk) disable iff (rst)
    (!idex_q.we && !exmem_q.we && !memwb_q.we) |-> !stall);

  // R2: an rs match in execute must stall
  a_r2_idex_hit: assert property (@(posedge clk) disable iff (rst)
    (ifid_q.vld && idex_q.we && idex_q.idx != '0 && idex_q.idx == ifid_q.rs)
      |-> stall);
endmodule

// File: tb/sim_raw_stall_pipe.sv
`timescale 1ns/1ps
module sim_raw_stall_pipe;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [4:0] p_rs [32];
  logic [4:0] p_rt [32];
  logic [4:0] p_wi [32];
  logic       p_rtu [32];
  logic       p_we  [32];

  logic [15:0] pc0, pc1;
  logic        st0, st1, bb0, bb1, we0, we1;
  logic [4:0]  wi0, wi1;

  raw_stall_pipe #(.MEMWB_HAZ(1'b1)) u0 (
    .clk (clk), .rst (rst),
    .in_rs (p_rs[pc0[6:2]]), .in_rt (p_rt[pc0[6:2]]),
    .in_rt_used (p_rtu[pc0[6:2]]),
    .in_wr_idx (p_wi[pc0[6:2]]), .in_wr_en (p_we[pc0[6:2]]),
    .pc (pc0), .stall (st0), .bubble (bb0), .wb_we (we0), .wb_idx (wi0)
  );

  raw_stall_pipe #(.MEMWB_HAZ(1'b0)) u1 (
    .clk (clk), .rst (rst),
    .in_rs (p_rs[pc1[6:2]]), .in_rt (p_rt[pc1[6:2]]),
    .in_rt_used (p_rtu[pc1[6:2]]),
    .in_wr_idx (p_wi[pc1[6:2]]), .in_wr_en (p_we[pc1[6:2]]),
    .pc (pc1), .stall (st1), .bubble (bb1), .wb_we (we1), .wb_idx (wi1)
  );

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  localparam int RUN = 20;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) begin
      p_rs[i] = '0; p_rt[i] = '0; p_wi[i] = '0; p_rtu[i] = 1'b0; p_we[i] = 1'b0;
    end
  endtask

  task automatic put(int a, int rs, int rt, bit rtu, int wi, bit we);
    p_rs[a] = 5'(rs); p_rt[a] = 5'(rt); p_rtu[a] = rtu;
    p_wi[a] = 5'(wi); p_we[a] = we;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Runs the loaded program on both instances and checks stalls, pc, bubbles and write order.
  task automatic run_case(string req, int es0, int es1, int nw, int e0, int e1, int e2);
    int s0 = 0, s1 = 0, b0 = 0, b1 = 0, c0 = 0, c1 = 0;
    int w0 [8];
    int w1 [8];
    int ew [3];
    ew[0] = e0; ew[1] = e1; ew[2] = e2;
    do_reset();
    for (int k = 0; k < RUN; k++) begin
      if (st0) s0++;
      if (st1) s1++;
      if (bb0) b0++;
      if (bb1) b1++;
      if (we0 && c0 < 8) begin w0[c0] = int'(wi0); c0++; end
      if (we1 && c1 < 8) begin w1[c1] = int'(wi1); c1++; end
      @(posedge clk);
      @(negedge clk);
    end
    chk({req, " stalls (write-back counted)"}, s0, es0);
    chk({req, "/R8 stalls (write-back not counted)"}, s1, es1);
    chk("R6 pc after run", int'(pc0), 4 * (RUN - es0));
    chk("R6 pc after run, no write-back compare", int'(pc1), 4 * (RUN - es1));
    chk("R7 bubble cycles", b0, es0 + 1);
    chk("R7 write count", c0, nw);
    chk("R7 write count, no write-back compare", c1, nw);
    for (int i = 0; i < nw && i < 3; i++) begin
      if (i < c0) chk("R7 write order", w0[i], ew[i]);
      if (i < c1) chk("R7 write order, no write-back compare", w1[i], ew[i]);
    end
  endtask

  task automatic t_reset();
    clear_prog();
    do_reset();
    chk("R1 pc", int'(pc0), 0);
    chk("R1 stall", int'(st0), 0);
    chk("R1 bubble", int'(bb0), 1);
    chk("R1 wb_we", int'(we0), 0);
  endtask

  task automatic t_independent();
    clear_prog();
    put(0, 2, 3, 1, 1, 1);
    put(1, 5, 6, 1, 4, 1);
    run_case("R2 independent", 0, 0, 2, 1, 4, 0);
  endtask

  task automatic t_adjacent_rs();
    clear_prog();
    put(0, 1, 0, 0, 5, 1);
    put(1, 5, 0, 0, 6, 1);
    run_case("R2 adjacent rs", 3, 2, 2, 5, 6, 0);
  endtask

  task automatic t_rt_used();
    clear_prog();
    put(0, 1, 0, 0, 7, 1);
    put(1, 1, 7, 1, 8, 1);
    run_case("R3 rt read", 3, 2, 2, 7, 8, 0);
  endtask

  task automatic t_rt_unused();
    clear_prog();
    put(0, 1, 0, 0, 7, 1);
    put(1, 1, 7, 0, 8, 1);
    run_case("R3 rt not read", 0, 0, 2, 7, 8, 0);
  endtask

  task automatic t_zero();
    clear_prog();
    put(0, 1, 0, 0, 0, 1);
    put(1, 0, 0, 1, 9, 1);
    run_case("R5 index zero", 0, 0, 2, 0, 9, 0);
  endtask

  task automatic t_no_enable();
    clear_prog();
    put(0, 1, 0, 0, 5, 0);
    put(1, 5, 0, 0, 6, 1);
    run_case("R4 write disabled", 0, 0, 1, 6, 0, 0);
  endtask

  task automatic t_gap1();
    clear_prog();
    put(0, 1, 0, 0, 5, 1);
    put(1, 11, 0, 0, 10, 1);
    put(2, 5, 0, 0, 12, 1);
    run_case("R9 gap of one", 2, 1, 3, 5, 10, 12);
  endtask

  task automatic t_gap2();
    clear_prog();
    put(0, 1, 0, 0, 5, 1);
    put(1, 1, 0, 0, 10, 1);
    put(2, 1, 0, 0, 11, 1);
    put(3, 5, 0, 0, 12, 1);
    run_case("R9 gap of two", 1, 0, 4, 5, 10, 11);
  endtask

  task automatic t_gap3();
    clear_prog();
    put(0, 1, 0, 0, 5, 1);
    put(1, 1, 0, 0, 10, 1);
    put(2, 1, 0, 0, 11, 1);
    put(3, 1, 0, 0, 13, 1);
    put(4, 5, 0, 0, 12, 1);
    run_case("R9 gap of three", 0, 0, 5, 5, 10, 11);
  endtask

  task automatic t_two_sources();
    clear_prog();
    put(0, 3, 0, 0, 1, 1);
    put(1, 3, 0, 0, 2, 1);
    put(2, 2, 1, 1, 4, 1);
    run_case("R10 rs and rt in different stages", 3, 2, 3, 1, 2, 4);
  endtask

  initial begin
    t_reset();
    t_independent();
    t_adjacent_rs();
    t_rt_used();
    t_rt_unused();
    t_zero();
    t_no_enable();
    t_gap1();
    t_gap2();
    t_gap3();
    t_two_sources();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule